// File: doc/BRIEF.md
# Fractional 16x Baud Tick Generator

This block turns a UART reference clock into the enable tick that paces 16x oversampling for both the transmitter and the receiver. Software works out a total divisor in sixteenths: the reference frequency over the baud rate, rounded to the nearest integer by adding half the baud rate before dividing. The low four bits of that total are the fraction. The rest, divided by sixteen, is the integer part and is stored minus one. The integer is held in two fields. The low byte sits in bits 7:0 of the low divisor word and the upper bits sit in the high divisor word. The fraction nibble sits in bits 15:12 of the low divisor word.

Each tick period lasts the stored integer plus one reference cycles. A four-bit phase accumulator adds the fraction once per tick and stretches a period by one cycle whenever it carries. Sixteen ticks therefore span exactly the total divisor, and the long periods are spread evenly among the short ones. A divisor offered on the update strobe is held as pending. It becomes active only at a tick boundary, so no period is ever cut short or lengthened midway. The fastest rate, the reference clock over sixteen, stores integer 0 and fraction 0, and gives a tick on every cycle.

Top module: `fracBaudTickGen`

## Requirements
- R1: On `divUpdate` the block captures the stored integer as {`divHigh`, `divLow[7:0]`} and the fraction as `divLow[15:12]`. Bits 11:8 of `divLow` have no effect. For a rate the total divisor is T = (ref + baud/2) / baud, the fraction is T mod 16 and the stored integer is T/16 - 1.
- R2: Every interval between two ticks is either stored integer + 1 or stored integer + 2 reference cycles, using the divisor active for that period.
- R3: At each tick a 4-bit accumulator (reset value 0) adds the fraction. The period that follows is stretched by one cycle exactly when that addition carries. Over any 16 consecutive ticks with a constant divisor, exactly fraction-many periods are stretched and the total is 16*(integer+1)+fraction = T cycles.
- R4: `tick` is high for one cycle and low on the next cycle, unless the following period is one cycle long (stored integer 0 and no stretch). With integer 0 and fraction 0, `tick` stays high on every cycle.
- R5: A divisor captured while a period is running does not change the length of that period. It governs the period that starts at the next tick.
- R6: A divisor captured on the same clock edge that ends a tick period is not used for the period that starts at that edge. It governs the period after that one.
- R7: While `rstN` is low, `tick` is low, the pending and active divisors take the defaults `DEF_INT`/`DEF_FRAC`, and the accumulator clears. The first tick comes `DEF_INT` rising edges after release, and that first period is never stretched.
- R8: The accumulator is not cleared when the divisor changes. The stretch of the first period under a new fraction depends on the phase left by earlier ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | UART reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| divLow | input | LO_W (16) | Low divisor word: integer low byte in 7:0, fraction in 15:12 |
| divHigh | input | HI_W | Upper bits of the stored integer |
| divUpdate | input | 1 | One-cycle strobe that captures `divLow`/`divHigh` as the pending divisor |
| tick | output | 1 | 16x oversampling enable pulse |

## Verification
The bench builds the block with `HI_W` = 4, which gives a 12-bit stored integer. That is wide enough to need the upper field for 2400 baud from a 100 MHz reference, yet short enough that sixteen such periods fit comfortably in the run. `DEF_INT` = 3 and `DEF_FRAC` = 5 give a short fractional reset divisor, so the reset path reaches dithering within a few dozen cycles. The rate table runs from the fastest setting, a tick every cycle, up to divisors above 40,000 sixteenths. It also changes the fraction from one entry to the next, so the carried accumulator phase and the edge-coincident update are both visible at the ports.

// File: rtl/fracBaudPkg.sv
package fracBaudPkg;

  // Strobes from the control to the counting datapath, valid in a tick cycle.
  typedef struct packed {
    logic boundary;  // current period ends at this edge, reload counter
    logic stretch;   // next period gets one extra reference cycle
  } tickStrobeT;

endpackage

// File: rtl/tickDatapath.sv
module tickDatapath
  import fracBaudPkg::*;
#(
  parameter int LO_W      = 16,
  parameter int LO_BYTE_W = 8,
  parameter int HI_W      = 8,
  parameter int FRAC_W    = 4,
  parameter int DEF_INT   = 13,
  parameter int DEF_FRAC  = 10,
  localparam int INT_W    = LO_BYTE_W + HI_W,
  localparam int CNT_W    = INT_W + 1,
  localparam int FRAC_LSB = LO_W - FRAC_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LO_W-1:0]   divLow,
  input  logic [HI_W-1:0]   divHigh,
  input  logic              divUpdate,
  input  tickStrobeT        strb,
  output logic              atZero,
  output logic [FRAC_W-1:0] pendFrac,
  output logic [INT_W-1:0]  actInt
);

  logic [INT_W-1:0] pendInt;
  logic [CNT_W-1:0] cnt;
  logic             unusedGapBits;

  // Bits between the integer byte and the fraction carry no meaning.
  assign unusedGapBits = ^divLow[FRAC_LSB-1:LO_BYTE_W];

  // Pending copy: written by the update strobe at any time.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendInt  <= INT_W'(DEF_INT);
      pendFrac <= FRAC_W'(DEF_FRAC);
    end else if (divUpdate) begin
      pendInt  <= {divHigh, divLow[LO_BYTE_W-1:0]};
      pendFrac <= divLow[LO_W-1:FRAC_LSB];
    end
  end

  // Active integer: only moves at a tick boundary.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actInt <= INT_W'(DEF_INT);
    end else if (strb.boundary) begin
      actInt <= pendInt;
    end
  end

  // Down counter: a period of length N runs N-1 .. 0.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= CNT_W'(DEF_INT);
    end else if (strb.boundary) begin
      cnt <= {1'b0, pendInt} + CNT_W'(strb.stretch);
    end else begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  assign atZero = (cnt == '0);

endmodule

// File: rtl/tickControl.sv
module tickControl
  import fracBaudPkg::*;
#(
  parameter int FRAC_W   = 4,
  parameter int DEF_FRAC = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              atZero,
  input  logic [FRAC_W-1:0] pendFrac,
  output tickStrobeT        strb,
  output logic [FRAC_W-1:0] actFrac,
  output logic              stretchQ
);

  logic [FRAC_W-1:0] phaseAcc;
  logic [FRAC_W:0]   phaseSum;

  assign phaseSum      = {1'b0, phaseAcc} + {1'b0, pendFrac};
  assign strb.boundary = atZero;
  assign strb.stretch  = phaseSum[FRAC_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseAcc <= '0;
      actFrac  <= FRAC_W'(DEF_FRAC);
      stretchQ <= 1'b0;
    end else if (atZero) begin
      phaseAcc <= phaseSum[FRAC_W-1:0];
      actFrac  <= pendFrac;
      stretchQ <= phaseSum[FRAC_W];
    end
  end

endmodule

// File: rtl/fracBaudTickGen.sv
module fracBaudTickGen
  import fracBaudPkg::*;
#(
  parameter int LO_W      = 16,
  parameter int LO_BYTE_W = 8,
  parameter int HI_W      = 8,
  parameter int FRAC_W    = 4,
  parameter int DEF_INT   = 13,
  parameter int DEF_FRAC  = 10,
  localparam int INT_W    = LO_BYTE_W + HI_W
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [LO_W-1:0] divLow,
  input  logic [HI_W-1:0] divHigh,
  input  logic            divUpdate,
  output logic            tick
);

  tickStrobeT        strb;
  logic              atZero;
  logic [FRAC_W-1:0] pendFrac;
  logic [INT_W-1:0]  actInt;
  logic [FRAC_W-1:0] actFrac;
  logic              stretchQ;

  tickDatapath #(
    .LO_W(LO_W), .LO_BYTE_W(LO_BYTE_W), .HI_W(HI_W), .FRAC_W(FRAC_W),
    .DEF_INT(DEF_INT), .DEF_FRAC(DEF_FRAC)
  ) u_dp (
    .clk(clk), .rstN(rstN), .divLow(divLow), .divHigh(divHigh),
    .divUpdate(divUpdate), .strb(strb), .atZero(atZero),
    .pendFrac(pendFrac), .actInt(actInt)
  );

  tickControl #(
    .FRAC_W(FRAC_W), .DEF_FRAC(DEF_FRAC)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .atZero(atZero), .pendFrac(pendFrac),
    .strb(strb), .actFrac(actFrac), .stretchQ(stretchQ)
  );

  assign tick = atZero;

endmodule

// File: rtl/tickGenChecker.sv
module tickGenChecker #(
  parameter int INT_W    = 16,
  parameter int FRAC_W   = 4,
  parameter int DEF_INT  = 13,
  parameter int DEF_FRAC = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              tick,
  input logic [INT_W-1:0]  curInt,
  input logic [FRAC_W-1:0] curFrac,
  input logic              curStretch
);

  logic [INT_W+1:0] gapCnt;
  logic             inRst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     gapCnt <= '0;
    else if (tick) gapCnt <= '0;
    else           gapCnt <= gapCnt + 1'b1;
  end

  // R7
  always_ff @(posedge clk) begin
    inRst <= !rstN;
    if (inRst && rstN) begin
      reset_state_chk: assert (curInt == INT_W'(DEF_INT) && curFrac == FRAC_W'(DEF_FRAC) && !curStretch && !tick);
    end
  end

  // R5
  stable_div_chk: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> ($stable(curInt) && $stable(curFrac)));

  // R4
  pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> (!tick || (curInt == '0 && !curStretch)));

  // R2
  period_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    tick |-> (gapCnt == ((INT_W+2)'(curInt) + (INT_W+2)'(curStretch))));

  // R3
  stretch_frac_chk: assert property (@(posedge clk) disable iff (!rstN)
    curStretch |-> (curFrac != '0));

endmodule

bind fracBaudTickGen tickGenChecker #(
  .INT_W(LO_BYTE_W + HI_W), .FRAC_W(FRAC_W),
  .DEF_INT(DEF_INT), .DEF_FRAC(DEF_FRAC)
) u_chk (
  .clk(clk), .rstN(rstN), .tick(tick), .curInt(actInt),
  .curFrac(actFrac), .curStretch(stretchQ)
);

// File: tb/fracBaudTickGen_tb.sv
`timescale 1ns/1ps
module fracBaudTickGen_tb;

  localparam int HI_W     = 4;
  localparam int DEF_INT  = 3;
  localparam int DEF_FRAC = 5;
  localparam int NVEC     = 8;

  // {reference Hz, baud, expected total divisor in sixteenths}
  localparam logic [95:0] VEC [NVEC] = '{
    {32'd27000000,  32'd115200,  32'd234},
    {32'd27000000,  32'd921600,  32'd29},
    {32'd27000000,  32'd1687500, 32'd16},
    {32'd48000000,  32'd115200,  32'd417},
    {32'd50000000,  32'd3000000, 32'd17},
    {32'd27000000,  32'd230400,  32'd117},
    {32'd100000000, 32'd9600,    32'd10417},
    {32'd100000000, 32'd2400,    32'd41667}
  };

  logic            clk = 1'b0;
  logic            rstN;
  logic [15:0]     divLow;
  logic [HI_W-1:0] divHigh;
  logic            divUpdate;
  logic            tick;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int lastCyc;
  int mPendInt, mPendFrac, mAcc, mNext;

  fracBaudTickGen #(.HI_W(HI_W), .DEF_INT(DEF_INT), .DEF_FRAC(DEF_FRAC)) u_dut (
    .clk(clk), .rstN(rstN), .divLow(divLow), .divHigh(divHigh),
    .divUpdate(divUpdate), .tick(tick)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic checkEq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Model of the next period, evaluated at each tick.
  task automatic advanceModel();
    int s;
    s     = mAcc + mPendFrac;
    mNext = mPendInt + 1 + ((s >= 16) ? 1 : 0);
    mAcc  = s % 16;
  endtask

  task automatic waitTick(output int gap);
    do begin
      @(negedge clk);
      divUpdate = 1'b0;
    end while (!tick);
    gap     = cyc - lastCyc;
    lastCyc = cyc;
  endtask

  task automatic tickAndCheck(input string req, input bit doPeek, output int gap);
    waitTick(gap);
    checkEq(req, gap, mNext);
    advanceModel();
    if (doPeek && mNext > 1) begin
      @(negedge clk);
      divUpdate = 1'b0;
      checkEq("R4 tick low after pulse", int'(tick), 0);
    end
  endtask

  task automatic driveDiv(input int i, input int f, input logic [3:0] junk);
    logic [11:0] iv;
    iv        = 12'(i);
    divLow    = {4'(f), junk, iv[7:0]};
    divHigh   = HI_W'(i >> 8);
    divUpdate = 1'b1;
    mPendInt  = i;
    mPendFrac = f;
  endtask

  task automatic resetModel();
    mAcc      = 0;
    mPendInt  = DEF_INT;
    mPendFrac = DEF_FRAC;
    mNext     = DEF_INT;
    lastCyc   = cyc;
  endtask

  initial begin
    #(150000 * 5);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int gap, sum, st, total, fi, ii;
    rstN = 1'b0; divLow = '0; divHigh = '0; divUpdate = 1'b0;

    // R7: tick low throughout reset
    repeat (4) begin
      @(negedge clk);
      checkEq("R7 tick in reset", int'(tick), 0);
    end
    rstN = 1'b1;
    resetModel();
    tickAndCheck("R7 first period", 1'b1, gap);
    sum = 0;
    for (int k = 0; k < 16; k++) begin
      tickAndCheck("R3 default", k != 15, gap);
      sum += gap;
    end
    checkEq("R7 default sixteen-tick span", sum, 16 * (DEF_INT + 1) + DEF_FRAC);

    // Rate table
    for (int v = 0; v < NVEC; v++) begin
      longint refHz, baud;
      refHz = longint'(VEC[v][95:64]);
      baud  = longint'(VEC[v][63:32]);
      total = int'((refHz + baud / 2) / baud);
      fi    = total % 16;
      ii    = total / 16 - 1;
      // Drive in the tick cycle: coincident capture (R6); odd entries put junk in 11:8 (R1)
      driveDiv(ii, fi, (v % 2 == 1) ? 4'hF : 4'h0);
      tickAndCheck("R6 coincident update deferred", 1'b1, gap);
      sum = 0;
      st  = 0;
      for (int k = 0; k < 16; k++) begin
        tickAndCheck((k == 0) ? "R8 carried phase" : "R2 period", k != 15, gap);
        sum += gap;
        if (gap == ii + 2) st++;
      end
      checkEq("R1 R3 sixteen-tick span", sum, int'(VEC[v][31:0]));
      checkEq("R3 stretched count", st, fi);
    end

    // R5: an update in mid-period leaves that period alone
    driveDiv(40, 0, 4'h0);
    tickAndCheck("R6 transitional", 1'b1, gap);
    tickAndCheck("R2 long period", 1'b0, gap);
    repeat (10) begin
      @(negedge clk);
      divUpdate = 1'b0;
    end
    driveDiv(5, 0, 4'h0);
    tickAndCheck("R5 running period kept", 1'b1, gap);
    tickAndCheck("R5 new divisor at next period", 1'b1, gap);

    // R7: reset in mid-run restores defaults
    @(negedge clk);
    divUpdate = 1'b0;
    rstN = 1'b0;
    repeat (3) begin
      @(negedge clk);
      checkEq("R7 tick in second reset", int'(tick), 0);
    end
    rstN = 1'b1;
    resetModel();
    tickAndCheck("R7 first period after second reset", 1'b1, gap);
    sum = 0;
    for (int k = 0; k < 16; k++) begin
      tickAndCheck("R7 default period", 1'b1, gap);
      sum += gap;
    end
    checkEq("R7 default span after second reset", sum, 16 * (DEF_INT + 1) + DEF_FRAC);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule